// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a 32-bit register bus and a small on-chip flash array. It sequences three kinds of operation on the array: programming a 128-bit line, erasing one page, and erasing the whole array. Software loads an address and four data words. It then writes a control word that carries an unlock key, an erase selector and exactly one command bit. The command bit stays set until the operation completes. A completion flag and an access-fault flag, each with its own enable, drive a single interrupt line.

The array is a register-based model that erases to all ones. Programming can only clear bits: the stored line becomes the AND of its old contents and the new data. Operation length is counted in ticks. A tick is a programmable number of bus clocks, chosen so that one tick is about one microsecond. A separate read port returns any stored line without delay.

Register offsets used on `bus_addr`:

- `0x00`: target byte address.
- `0x04`: clock divider, bits 7:0.
- `0x08`: control word. The command bits are write bit 0, mass erase bit 1 and page erase bit 2. Bits 15:8 hold the erase selector. Bit 16 is the read-only pending bit. Bits 31:28 hold the key.
- `0x0C`: flags and enables. DONE is bit 0 and FAULT is bit 1. The DONE enable is bit 8 and the FAULT enable is bit 9.
- `0x10` to `0x1C`: data words 0 to 3. Word 0 holds line bits 31:0.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, the control and flag registers read zero, `irq` is low and every array line reads all ones.
- R2: A control write that sets a command bit while the key field (bits 31:28) is not 4'h2 starts nothing, leaves the array unchanged and sets FAULT. Clearing the key therefore relocks the block.
- R3: An accepted write command (control bit 0) stores the old line AND the four data words at line index address[7:4]. Bits can only go from one to zero.
- R4: A write command is rejected, and FAULT is set, when the address has nonzero bits 3:0 or lies beyond the array. The array is left unchanged.
- R5: After a write command is accepted, pending (control bit 16) reads one for exactly one cycle while the line is transferred. Busy (any command bit) is set whenever pending is.
- R6: A command bit stays set for N×D bus cycles after the accepting edge. N is the tick count of that operation and D is the divider value, with 0 treated as 1.
- R7: Page erase (control bit 2, selector 8'h55) sets to all ones every line of the page that holds the address. All other lines keep their contents.
- R8: Mass erase (control bit 1, selector 8'hAA) sets every line to all ones and does not depend on the address register.
- R9: A command whose selector does not match its erase bit, or a control write with more than one command bit set, is rejected and sets FAULT.
- R10: DONE is set on the same edge at which the command bit clears.
- R11: Writing 0 to DONE or FAULT clears it. Writing 1 leaves it unchanged.
- R12: `irq` is high exactly when (DONE and its enable) or (FAULT and its enable) holds.
- R13: While busy, writes to the address, control or data registers are ignored and set FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_re` is low |
| rd_line | input | LW | Array line index for the read port |
| rd_data | output | 128 | Contents of the selected array line |
| irq | output | 1 | Masked flag interrupt |

## Verification
The bench builds the block with 16 lines of 4 lines per page and tick counts of 3, 5 and 7 for write, page erase and mass erase. Because the three lengths differ, a command that ran for the wrong operation's duration is caught. The divider is set to 1, 2 and 0 across the tests. This checks the N×D length of R6, including the case where a zero divider counts as one. With four pages, erasing page 1 can be seen to leave page 2 untouched. A mass-erase address placed beyond the array shows that the address register is ignored for that command.

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
  parameter int LINES      = 16,
  parameter int PAGE_LINES = 4,
  parameter int T_WRITE    = 2,
  parameter int T_PAGE     = 4,
  parameter int T_MASS     = 6,
  parameter logic [3:0] KEY_OPEN  = 4'h2,
  parameter logic [7:0] CODE_PAGE = 8'h55,
  parameter logic [7:0] CODE_ALL  = 8'hAA,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [4:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [LW-1:0] rd_line,
  output logic [127:0]  rd_data,
  output logic          irq
);
  localparam int PW = $clog2(PAGE_LINES);
  localparam int TMAX = (T_MASS > T_PAGE ? (T_MASS > T_WRITE ? T_MASS : T_WRITE)
                                         : (T_PAGE > T_WRITE ? T_PAGE : T_WRITE));
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [31:0] LIMIT = 32'(LINES * 16);

  logic [31:0]  addr_q;
  logic [7:0]   div_q, divcnt, code_q;
  logic [3:0]   key_q;
  logic [2:0]   cmd_q;
  logic         pend_q, done_q, fault_q, den_q, fen_q;
  logic [31:0]  data_q [4];
  logic [TW-1:0] tcnt;
  logic [127:0] mem [LINES];

  wire busy     = |cmd_q;
  wire we_addr  = bus_we && bus_addr == 5'h00;
  wire we_div   = bus_we && bus_addr == 5'h04;
  wire we_ctrl  = bus_we && bus_addr == 5'h08;
  wire we_irq   = bus_we && bus_addr == 5'h0C;
  wire we_data  = bus_we && bus_addr[4] && bus_addr[1:0] == 2'b00;

  wire [2:0] new_cmd  = bus_wdata[2:0];
  wire [7:0] new_code = bus_wdata[15:8];
  wire [3:0] new_key  = bus_wdata[31:28];
  wire out_rng = addr_q >= LIMIT;

  wire start_req = we_ctrl && !busy && |new_cmd;
  wire bad = new_key != KEY_OPEN
          || (new_cmd & (new_cmd - 3'd1)) != 3'd0
          || (new_cmd[0] && (addr_q[3:0] != 4'd0 || out_rng))
          || (new_cmd[1] && new_code != CODE_ALL)
          || (new_cmd[2] && (new_code != CODE_PAGE || out_rng));
  wire accept    = start_req && !bad;
  wire busy_hit  = busy && (we_ctrl || we_addr || we_data);
  wire fault_set = (start_req && bad) || busy_hit;

  wire [7:0]    dlim     = (div_q == 8'd0) ? 8'd1 : div_q;
  wire          tick_end = divcnt >= dlim - 8'd1;
  wire [TW-1:0] tlen     = cmd_q[0] ? TW'(T_WRITE) : cmd_q[1] ? TW'(T_MASS) : TW'(T_PAGE);
  wire          finish   = busy && tick_end && (tcnt + TW'(1) == tlen);

  wire [LW-1:0] wline = addr_q[LW+3:4];
  wire [LW-PW-1:0] wpage = addr_q[LW+3:PW+4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; div_q <= '0; key_q <= '0; code_q <= '0; cmd_q <= '0;
      pend_q <= 1'b0; done_q <= 1'b0; fault_q <= 1'b0; den_q <= 1'b0; fen_q <= 1'b0;
      divcnt <= '0; tcnt <= '0;
      for (int i = 0; i < 4; i++) data_q[i] <= '0;
    end else begin
      if (we_addr && !busy) addr_q <= bus_wdata;
      if (we_div) div_q <= bus_wdata[7:0];
      if (we_data && !busy) data_q[bus_addr[3:2]] <= bus_wdata;
      if (we_ctrl && !busy) begin
        key_q  <= new_key;
        code_q <= new_code;
        if (accept) begin
          cmd_q  <= new_cmd;
          pend_q <= new_cmd[0];
          divcnt <= '0;
          tcnt   <= '0;
        end
      end else if (busy) begin
        pend_q <= 1'b0;
        if (tick_end) begin
          divcnt <= '0;
          tcnt   <= tcnt + TW'(1);
          if (finish) cmd_q <= '0;
        end else begin
          divcnt <= divcnt + 8'd1;
        end
      end
      if (we_irq) begin
        den_q <= bus_wdata[8];
        fen_q <= bus_wdata[9];
      end
      done_q  <= finish    | (done_q  & ~(we_irq & ~bus_wdata[0]));
      fault_q <= fault_set | (fault_q & ~(we_irq & ~bus_wdata[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '1;
    end else begin
      if (pend_q)
        mem[wline] <= mem[wline] & {data_q[3], data_q[2], data_q[1], data_q[0]};
      if (finish && cmd_q[1])
        for (int i = 0; i < LINES; i++) mem[i] <= '1;
      if (finish && cmd_q[2])
        for (int i = 0; i < LINES; i++)
          if ((i / PAGE_LINES) == int'(wpage)) mem[i] <= '1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        5'h00:   bus_rdata = addr_q;
        5'h04:   bus_rdata = {24'd0, div_q};
        5'h08:   bus_rdata = {key_q, 11'd0, pend_q, code_q, 5'd0, cmd_q};
        5'h0C:   bus_rdata = {22'd0, fen_q, den_q, 6'd0, fault_q, done_q};
        5'h10:   bus_rdata = data_q[0];
        5'h14:   bus_rdata = data_q[1];
        5'h18:   bus_rdata = data_q[2];
        5'h1C:   bus_rdata = data_q[3];
        default: bus_rdata = '0;
      endcase
    end
  end

  assign rd_data = mem[rd_line];
  assign irq = (done_q & den_q) | (fault_q & fen_q);
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk #(
  parameter logic [3:0] KEY = 4'h2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [4:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [2:0]  cmd,
  input logic        pend,
  input logic        done,
  input logic        fault,
  input logic        den,
  input logic        fen,
  input logic        irq,
  input logic [31:0] addr_q
);
  wire busy = |cmd;

  // R5
  pend_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> busy);

  // R10
  done_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2
  locked_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h08 && !busy && bus_wdata[2:0] != 3'd0 && bus_wdata[31:28] != KEY)
      |=> (fault && !busy));

  // R13
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_addr == 5'h00) |=> ($stable(addr_q) && fault));

  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!den && !fen) |-> !irq);
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.KEY(KEY_OPEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cmd(cmd_q), .pend(pend_q), .done(done_q), .fault(fault_q), .den(den_q), .fen(fen_q),
  .irq(irq), .addr_q(addr_q)
);

// File: tb/flash_pe_ctrl_bench.sv
module flash_pe_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] rd_line = '0;
  logic [127:0] rd_data;
  logic irq;
  int checks = 0, fails = 0;

  localparam logic [4:0] A_ADDR = 5'h00, A_DIV = 5'h04, A_CTRL = 5'h08, A_IRQ = 5'h0C;
  localparam logic [127:0] ONES = '1;

  always #5 clk = ~clk;

  flash_pe_ctrl #(.LINES(16), .PAGE_LINES(4), .T_WRITE(3), .T_PAGE(5), .T_MASS(7)) u_flash_pe_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_line(rd_line), .rd_data(rd_data), .irq(irq));

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic line(input int idx, output logic [127:0] d);
    rd_line = 4'(idx);
    #1 d = rd_data;
  endtask

  task automatic load(input logic [31:0] d3, input logic [31:0] d2, input logic [31:0] d1, input logic [31:0] d0);
    wr(5'h10, d0); wr(5'h14, d1); wr(5'h18, d2); wr(5'h1C, d3);
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] c;
    n = 0;
    rd(A_CTRL, c);
    while (c[2:0] != 3'd0 && n < 1000) begin
      @(negedge clk);
      n++;
      rd(A_CTRL, c);
    end
    if (n >= 1000) check("watchdog busy", 1, 0);
  endtask

  task automatic t_reset;
    logic [31:0] v; logic [127:0] l;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_IRQ, v);  check("R1 flags", v, 0);
    check("R1 irq", irq, 0);
    line(0, l);  check("R1 line0", l, ONES);
    line(15, l); check("R1 line15", l, ONES);
  endtask

  task automatic t_locked;
    logic [31:0] v; logic [127:0] l;
    wr(A_ADDR, 32'h20); load(0, 0, 0, 0);
    wr(A_CTRL, 32'h0000_0001);
    rd(A_CTRL, v); check("R2 not busy", v[2:0], 0);
    rd(A_IRQ, v);  check("R2 fault", v[1], 1);
    line(2, l);    check("R2 array", l, ONES);
    wr(A_IRQ, 32'h0);
    rd(A_IRQ, v);  check("R11 clear by zero", v, 0);
  endtask

  task automatic t_write;
    logic [31:0] v; logic [127:0] l; int n;
    wr(A_DIV, 1);
    wr(A_ADDR, 32'h20);
    load(32'hFFFF0000, 32'hF0F0F0F0, 32'h12345678, 32'hFFFFFFFF);
    wr(A_CTRL, 32'h2000_0001);
    rd(A_CTRL, v); check("R5 pending set", v[16], 1);
    wait_idle(n);
    check("R6 write length", n, 3);
    rd(A_IRQ, v); check("R10 done", v[0], 1);
    line(2, l); check("R3 first write", l, 128'hFFFF0000_F0F0F0F0_12345678_FFFFFFFF);
    load(32'hFFFFFFFF, 32'hFF00FF00, 32'hFFFFFFFF, 32'h0000FFFF);
    wr(A_CTRL, 32'h2000_0001);
    @(negedge clk);
    rd(A_CTRL, v);
    check("R5 pending cleared", v[16], 0);
    check("R5 still busy", v[0], 1);
    wait_idle(n);
    check("R6 write length 2", n, 2);
    line(2, l); check("R3 and-only", l, 128'hFFFF0000_F000F000_12345678_0000FFFF);
    wr(A_IRQ, 32'h1);
    rd(A_IRQ, v); check("R11 one keeps done", v[0], 1);
    wr(A_IRQ, 32'h0);
  endtask

  task automatic t_bad;
    logic [31:0] v; logic [127:0] l;
    wr(A_ADDR, 32'h24); wr(A_CTRL, 32'h2000_0001);
    rd(A_CTRL, v); check("R4 unaligned idle", v[2:0], 0);
    rd(A_IRQ, v);  check("R4 unaligned fault", v[1], 1);
    line(2, l);    check("R4 array kept", l, 128'hFFFF0000_F000F000_12345678_0000FFFF);
    wr(A_IRQ, 0);
    wr(A_ADDR, 32'h100); wr(A_CTRL, 32'h2000_0001);
    rd(A_IRQ, v);  check("R4 range fault", v[1], 1);
    wr(A_IRQ, 0);
    wr(A_ADDR, 32'h40); wr(A_CTRL, 32'h2000_AA04);
    rd(A_CTRL, v); check("R9 code mismatch idle", v[2:0], 0);
    rd(A_IRQ, v);  check("R9 code mismatch fault", v[1], 1);
    wr(A_IRQ, 0);
    wr(A_CTRL, 32'h2000_AA03);
    rd(A_CTRL, v); check("R9 two commands idle", v[2:0], 0);
    rd(A_IRQ, v);  check("R9 two commands fault", v[1], 1);
    wr(A_IRQ, 0);
  endtask

  task automatic t_page;
    logic [127:0] l; int n;
    load(0, 0, 0, 0);
    wr(A_ADDR, 32'h50); wr(A_CTRL, 32'h2000_0001); wait_idle(n);
    wr(A_ADDR, 32'h80); wr(A_CTRL, 32'h2000_0001); wait_idle(n);
    line(5, l); check("R3 zero line5", l, 0);
    wr(A_DIV, 2);
    wr(A_ADDR, 32'h47); wr(A_CTRL, 32'h2000_5504);
    wait_idle(n);
    check("R6 page length", n, 10);
    line(5, l); check("R7 page erased", l, ONES);
    line(8, l); check("R7 other page kept", l, 0);
    wr(A_IRQ, 0);
  endtask

  task automatic t_mass;
    logic [31:0] v; logic [127:0] l; int n;
    wr(A_DIV, 0);
    wr(A_ADDR, 32'h100); wr(A_CTRL, 32'h2000_AA02);
    wait_idle(n);
    check("R6 mass length div0", n, 7);
    line(8, l); check("R8 line8", l, ONES);
    line(2, l); check("R8 line2", l, ONES);
    rd(A_IRQ, v); check("R8 no fault", v[1], 0);
    wr(A_IRQ, 0);
    wr(A_CTRL, 32'h2000_AA02);
    wr(A_ADDR, 32'h0);
    wr(5'h10, 32'h1234);
    wait_idle(n);
    rd(A_ADDR, v); check("R13 addr ignored", v, 32'h100);
    rd(5'h10, v);  check("R13 data ignored", v, 0);
    rd(A_IRQ, v);  check("R13 fault", v[1:0], 2'b11);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    check("R12 masked", irq, 0);
    wr(A_IRQ, 32'h103);
    #1 check("R12 done enabled", irq, 1);
    wr(A_IRQ, 32'h202);
    #1 check("R12 fault enabled", irq, 1);
    wr(A_IRQ, 32'h200);
    #1 check("R12 fault cleared", irq, 0);
    rd(A_IRQ, v); check("R11 flags after clear", v, 32'h200);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h0000_AA02);
    rd(A_CTRL, v); check("R2 relocked idle", v[2:0], 0);
    #1 check("R2 relock irq", irq, 1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_locked;
    t_write;
    t_bad;
    t_page;
    t_mass;
    t_irq;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule